// File: doc/BRIEF.md
# QoS-Promoting Read Command Queue

This block buffers read commands that arrive from a fabric-side address channel and passes them, oldest first, to a downstream memory port. Each command carries a 4-bit quality-of-service value. That value comes either from the fabric with the command or from a static register field. The value is stored alongside the address when the command is accepted.

The block also limits how many issued reads may be waiting for completion at once. The limit is one of two 4-bit caps, and a live fabric input can choose between them. Each completion pulse frees one slot. When promotion is switched on, the command at the head of the queue is presented with the highest QoS found among all queued commands. A command with high priority that is stuck behind a command with low priority therefore lifts the command in front of it.

A small word-addressed register port holds the control fields, the two caps and the static QoS. The width-mode flag is only stored and made visible. It changes nothing in the command path.

Top module: `rdq_qos_promote`

## Requirements
- R1: The control register at word 0 holds four bits: [3] head promotion enable, [2] fabric cap-select enable, [1] fabric QoS enable, [0] width mode (1 = 32-bit, 0 = 64-bit). It resets to 0, bits 31:4 always read zero, and `mode32` mirrors bit 0.
- R2: Word 1 holds issue cap 0 in bits [3:0] and issue cap 1 in bits [7:4]. Word 2 holds the static QoS in bits [3:0]. All three fields reset to 0, and every other bit of these words and of word 3 reads zero.
- R3: With fabric QoS disabled, an accepted command takes the static QoS. With it enabled, it takes `cmd_qos`.
- R4: A command's stored QoS is fixed at acceptance. A later change to the static field, or a later command with a higher QoS, does not alter what the head shows while promotion is disabled.
- R5: With promotion enabled, `iss_qos` equals the maximum stored QoS over all queued commands. With promotion disabled, it equals the head's own stored QoS.
- R6: With fabric cap-select disabled, the outstanding limit is cap 0. With it enabled, the limit is cap 1 while `cap_sel` is high and cap 0 while it is low.
- R7: `iss_valid` is high only when the queue is non-empty and the outstanding count is below the selected limit. The count rises on each issue handshake and falls on each `rd_done` pulse. It is unchanged when both happen in the same cycle.
- R8: If the limit falls to or below the outstanding count, nothing more issues until completions bring the count below the limit. Outstanding reads are never withdrawn.
- R9: The queue holds 8 commands. `cmd_ready` is low exactly when it is full, and commands issue in acceptance order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_valid | input | 1 | Fabric command valid |
| cmd_ready | output | 1 | Queue can accept a command |
| cmd_addr | input | 32 | Fabric read address |
| cmd_qos | input | 4 | Fabric QoS for this command |
| cap_sel | input | 1 | Fabric choice of cap 1 over cap 0 |
| iss_valid | output | 1 | Head command offered downstream |
| iss_ready | input | 1 | Downstream accepts the head |
| iss_addr | output | 32 | Head address |
| iss_qos | output | 4 | Head effective QoS |
| rd_done | input | 1 | One read completed |
| mode32 | output | 1 | Stored width-mode flag |

## Verification
The assertions assume that `rd_done` never pulses while the outstanding count is zero, because a completion must have an issued read behind it. The stimulus keeps to this by pulsing completions only after it has counted at least as many issue handshakes as completions. The assertions also assume that `cmd_valid` holds steady only across the single cycles the bench drives. The bench pushes through a task that raises `cmd_valid` for exactly one cycle, and only while it expects `cmd_ready`.

// File: rtl/rdq_qos_promote.sv
module rdq_qos_promote #(
  parameter int DEPTH = 8,
  parameter int AW    = 32,
  parameter int QW    = 4,
  parameter int CAPW  = 4,
  parameter int RW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_addr,
  input  logic [RW-1:0] reg_wdata,
  output logic [RW-1:0] reg_rdata,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [QW-1:0] cmd_qos,
  input  logic          cap_sel,
  output logic          iss_valid,
  input  logic          iss_ready,
  output logic [AW-1:0] iss_addr,
  output logic [QW-1:0] iss_qos,
  input  logic          rd_done,
  output logic          mode32
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = PW + 1;

  logic [3:0]      ctrl;
  logic [CAPW-1:0] cap0, cap1;
  logic [QW-1:0]   sqos;

  logic [AW-1:0] addr_mem [DEPTH];
  logic [QW-1:0] qos_mem  [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] occ;
  logic [CAPW-1:0] outst;

  logic promo_en, capsel_en, fqos_en;
  logic push, pop;
  logic [CAPW-1:0] lim;
  logic [QW-1:0] head_qos, max_qos, in_qos;

  assign promo_en  = ctrl[3];
  assign capsel_en = ctrl[2];
  assign fqos_en   = ctrl[1];
  assign mode32    = ctrl[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      cap0 <= '0;
      cap1 <= '0;
      sqos <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        2'd0: ctrl <= reg_wdata[3:0];
        2'd1: begin
          cap0 <= reg_wdata[CAPW-1:0];
          cap1 <= reg_wdata[2*CAPW-1:CAPW];
        end
        2'd2: sqos <= reg_wdata[QW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: reg_rdata[3:0] = ctrl;
      2'd1: reg_rdata[2*CAPW-1:0] = {cap1, cap0};
      2'd2: reg_rdata[QW-1:0] = sqos;
      default: ;
    endcase
  end

  assign lim       = (capsel_en && cap_sel) ? cap1 : cap0;
  assign in_qos    = fqos_en ? cmd_qos : sqos;
  assign cmd_ready = (occ != CW'(DEPTH));
  assign iss_valid = (occ != '0) && (outst < lim);
  assign push      = cmd_valid && cmd_ready;
  assign pop       = iss_valid && iss_ready;
  assign iss_addr  = addr_mem[rd_ptr];
  assign head_qos  = qos_mem[rd_ptr];

  always_comb begin
    max_qos = head_qos;
    for (int i = 1; i < DEPTH; i++) begin
      if (CW'(i) < occ && qos_mem[rd_ptr + PW'(i)] > max_qos)
        max_qos = qos_mem[rd_ptr + PW'(i)];
    end
  end

  assign iss_qos = promo_en ? max_qos : head_qos;

  always_ff @(posedge clk) begin
    if (push) begin
      addr_mem[wr_ptr] <= cmd_addr;
      qos_mem[wr_ptr]  <= in_qos;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      occ <= occ + 1'b1;
      else if (pop && !push) occ <= occ - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                              outst <= '0;
    else if (pop && !rd_done)                outst <= outst + 1'b1;
    else if (!pop && rd_done && outst != '0) outst <= outst - 1'b1;
  end

  // R9
  full_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CW'(DEPTH)) |-> !cmd_ready);

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CW'(DEPTH));

  // R7
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rd_done) |=> (outst == $past(outst)));

  // R7
  issue_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !rd_done) |=> (outst == $past(outst) + 1'b1));

  // R8
  cap_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (outst >= lim) |-> !pop);

  // R5
  promo_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (promo_en && occ != '0) |-> (iss_qos >= head_qos));

  // R1
  ctrl_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 2'd0) |-> (reg_rdata[RW-1:4] == '0));
endmodule

// File: tb/rdq_qos_promote_bench.sv
module rdq_qos_promote_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_we = 0;
  logic [1:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [31:0] cmd_addr = 0;
  logic [3:0]  cmd_qos = 0;
  logic        cap_sel = 0;
  logic        iss_valid;
  logic        iss_ready = 0;
  logic [31:0] iss_addr;
  logic [3:0]  iss_qos;
  logic        rd_done = 0;
  logic        mode32;

  int checks = 0;
  int errors = 0;
  int fires = 0;
  logic [31:0] next_addr = 0;
  logic [31:0] exp_iss_addr = 0;

  rdq_qos_promote u_rdq_qos_promote (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_qos(cmd_qos),
    .cap_sel(cap_sel), .iss_valid(iss_valid), .iss_ready(iss_ready),
    .iss_addr(iss_addr), .iss_qos(iss_qos), .rd_done(rd_done), .mode32(mode32)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      fires <= 0;
      exp_iss_addr <= 0;
    end else if (iss_valid && iss_ready) begin
      fires <= fires + 1;
      exp_iss_addr <= exp_iss_addr + 1;
      checks++;
      if (iss_addr != exp_iss_addr) begin
        errors++;
        $display("FAIL R9 issue order: actual %0d expected %0d", iss_addr, exp_iss_addr);
      end
    end
  end

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; reg_we = 0; cmd_valid = 0; iss_ready = 0; rd_done = 0; cap_sel = 0;
    next_addr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string tag);
    reg_addr = a;
    #1;
    chk(int'(reg_rdata), exp, tag);
  endtask

  task automatic push(input logic [3:0] q);
    cmd_valid = 1; cmd_addr = next_addr; cmd_qos = q;
    @(negedge clk);
    cmd_valid = 0;
    next_addr = next_addr + 1;
  endtask

  task automatic done_pulse();
    rd_done = 1;
    @(negedge clk);
    rd_done = 0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 R2 reset state
    rd_chk(0, 0, "R1 ctrl reset");
    rd_chk(1, 0, "R2 caps reset");
    rd_chk(2, 0, "R2 static reset");
    rd_chk(3, 0, "R2 word3");
    chk(int'(cmd_ready), 1, "R9 ready after reset");
    chk(int'(iss_valid), 0, "R7 no issue with cap 0");
    // R1 readback sweep over all low nibbles plus upper noise
    for (int v = 0; v < 16; v++) begin
      wr(0, 32'hABCD_EF00 | v);
      rd_chk(0, v, "R1 ctrl readback");
      chk(int'(mode32), v & 1, "R1 mode flag");
    end
    // R2 cap readback
    for (int v = 0; v < 256; v += 17) begin
      wr(1, 32'hFFFF_FF00 | v);
      rd_chk(1, v, "R2 caps readback");
    end
    wr(2, 32'hFFFF_FFF5);
    rd_chk(2, 5, "R2 static readback");

    // R3 R4 static source, fixed at acceptance
    do_reset();
    wr(2, 9);
    push(3);
    chk(int'(iss_qos), 9, "R3 static qos");
    wr(2, 4);
    chk(int'(iss_qos), 9, "R4 held after static change");
    wr(0, 2);
    push(12);
    chk(int'(iss_qos), 9, "R4 head unchanged without promotion");

    // R5 R4 R3 exhaustive pair sweep, both promotion settings
    for (int pm = 0; pm < 2; pm++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          do_reset();
          wr(0, (pm << 3) | 2);
          push(4'(a));
          push(4'(b));
          chk(int'(iss_qos), (pm != 0) ? ((a > b) ? a : b) : a,
              pm != 0 ? "R5 promoted head" : "R4 unpromoted head");
        end

    // R5 deeper queue, third entry highest
    do_reset();
    wr(0, 4'b1010);
    push(1); push(2); push(11); push(3);
    chk(int'(iss_qos), 11, "R5 max over four");

    // R7 R9 cap sweep with cap 0
    for (int c = 0; c < 9; c++) begin
      do_reset();
      wr(1, c);
      iss_ready = 1;
      for (int k = 0; k < 8; k++) push(0);
      repeat (3) @(negedge clk);
      chk(fires, c, "R7 issued up to cap");
      if (c > 0 && c < 8) begin
        done_pulse();
        repeat (2) @(negedge clk);
        chk(fires, c + 1, "R7 completion frees slot");
      end
    end

    // R9 full queue
    do_reset();
    for (int k = 0; k < 8; k++) push(0);
    chk(int'(cmd_ready), 0, "R9 ready low when full");
    wr(1, 1);
    iss_ready = 1;
    @(negedge clk);
    chk(int'(cmd_ready), 1, "R9 ready back after issue");

    // R6 selection
    do_reset();
    wr(1, 32'h52);
    cap_sel = 1;
    iss_ready = 1;
    for (int k = 0; k < 8; k++) push(0);
    repeat (2) @(negedge clk);
    chk(fires, 2, "R6 select ignored when disabled");
    do_reset();
    wr(1, 32'h52);
    wr(0, 4);
    cap_sel = 1;
    iss_ready = 1;
    for (int k = 0; k < 8; k++) push(0);
    repeat (2) @(negedge clk);
    chk(fires, 5, "R6 cap1 selected");

    // R8 limit drops below outstanding
    cap_sel = 0;
    repeat (2) done_pulse();
    repeat (2) @(negedge clk);
    chk(fires, 5, "R8 no issue while count 3 cap 2");
    done_pulse();
    repeat (2) @(negedge clk);
    chk(fires, 5, "R8 no issue while count equals cap");
    done_pulse();
    repeat (2) @(negedge clk);
    chk(fires, 6, "R8 issue once below cap");

    // R7 simultaneous issue and completion
    do_reset();
    wr(1, 2);
    for (int k = 0; k < 4; k++) push(0);
    iss_ready = 1;
    @(negedge clk);
    iss_ready = 0;
    chk(fires, 1, "R7 first issue");
    iss_ready = 1; rd_done = 1;
    @(negedge clk);
    iss_ready = 0; rd_done = 0;
    chk(fires, 2, "R7 issue with completion");
    iss_ready = 1;
    repeat (3) @(negedge clk);
    iss_ready = 0;
    chk(fires, 3, "R7 count held on coincident events");

    finish_run();
  end
endmodule